// File: doc/BRIEF.md
# Flow classification hash engine

This block produces the keyed hash that a flow steering unit uses to pick a filter bucket and to build a signature for matching. A packed flow tuple of fourteen 32-bit words enters on a valid/ready handshake together with two 32-bit keys: one for the bucket hash and one for the signature hash. Word 0 holds the flow type, VM pool and VLAN bits. Words 1 to 13 hold addresses, ports and flex bytes.

Both keyed hashes are computed from the same accepted tuple by a combinational XOR tree. The results are registered in one stage. The result is a raw 32-bit bucket-key hash and a bucket index. The index keeps only as many low bits as the selected match mode and buffer-allocation size allow. The result also includes a combined signature word that carries the signature-key hash above the bucket index. A result stays on the output until the consumer takes it.

Top module: `flow_hash_engine`

## Requirements
- R1: `in_ready_o` is high whenever no result is held or `out_ready_i` is high. A tuple is accepted on a clock edge where `in_valid_i` and `in_ready_o` are both high.
- R2: `out_valid_o` rises on the clock edge that accepts a tuple. While `out_valid_o` is high and `out_ready_i` is low, all result outputs hold their values.
- R3: The raw hash is formed as follows. Let C be the XOR of words 1..13, where word n occupies tuple bits [32n+31:32n], and let F be word 0. Set hi = C ^ F ^ (F>>16) and lo = C with its 16-bit halves swapped. The result collects key bit 0 ? lo and key bit 16 ? hi. Then lo becomes lo ^ F ^ (F<<16). For i from 15 down to 1, the result collects key bit i ? lo>>i and key bit 16+i ? hi>>i.
- R4: Word 0 does not reach the term gated by key bit 0, but it does reach every term from key bits 1..15 and 16..31. With only word 0 = F nonzero and key 0x00010000, the raw hash is F ^ (F>>16). With key 0x00000001 the raw hash is 0.
- R5: A zero key yields a raw hash of zero.
- R6: With `mode_i`=0 (perfect), the bucket index keeps 11, 12 or 13 low raw-hash bits for `alloc_i` = 0, 1 or 2. Code 3 behaves as 2. The other index bits are zero.
- R7: With `mode_i`=1 (signature), the bucket index keeps 13, 14 or 15 low raw-hash bits for `alloc_i` = 0, 1 or 2. Code 3 behaves as 2.
- R8: `sig_word_o` carries bits [15:0] of the signature-key hash in bits [31:16] and the bucket index in bits [15:0].
- R9: After reset, `out_valid_o` is low and `in_ready_o` is high.
- R10: With `out_ready_i` held high, a tuple can be accepted on every cycle and each result appears in the cycle after its acceptance. A taken result with no new input drops `out_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Tuple and keys are valid |
| in_ready_o | output | 1 | Block can accept a tuple |
| tuple_i | input | 448 | Fourteen packed words, word 0 in bits 31:0 |
| bkt_key_i | input | 32 | Key for the raw/bucket hash |
| sig_key_i | input | 32 | Key for the signature hash |
| mode_i | input | 1 | 0 perfect, 1 signature |
| alloc_i | input | 2 | Allocation size code: 0 small, 1 medium, 2 and 3 large |
| out_valid_o | output | 1 | Result is valid |
| out_ready_i | input | 1 | Consumer takes the result |
| raw_hash_o | output | 32 | Bucket-key hash, unmasked |
| bucket_o | output | 16 | Masked bucket index |
| sig_word_o | output | 32 | Signature hash above the bucket index |

## Verification
Every result is due in the first cycle after the edge that accepts its tuple. The scoreboard records the cycle of acceptance for each expected item. The monitor compares the cycle in which an item first appears against that cycle plus one. While the consumer stalls, the monitor compares the held item again on every cycle, so a result that changes or arrives late is reported. All inputs are driven at the falling edge, and outputs are sampled shortly after it, so that each sample falls within the stable half of the cycle.

// File: rtl/flow_hash_pkg.sv
package flow_hash_pkg;
  typedef enum logic {
    MODE_PERFECT   = 1'b0,
    MODE_SIGNATURE = 1'b1
  } hash_mode_e;

  // allocation code 3 is treated as the largest size
  function automatic int unsigned alloc_step(input logic [1:0] alloc);
    return (alloc == 2'd3) ? 2 : int'(alloc);
  endfunction
endpackage

// File: rtl/keyed_hash.sv
module keyed_hash #(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 14
) (
  input  logic [NUM_WORDS*WORD_W-1:0] tuple_i,
  input  logic [WORD_W-1:0]           key_i,
  output logic [WORD_W-1:0]           hash_o
);
  localparam int unsigned HALF = WORD_W / 2;

  logic [WORD_W-1:0] flow_w, common_w, hi_w, lo_w, lo_mix;
  logic [WORD_W-1:0] lo_terms [1:HALF-1];
  logic [WORD_W-1:0] hi_terms [1:HALF-1];

  assign flow_w = tuple_i[WORD_W-1:0];

  always_comb begin
    common_w = '0;
    for (int w = 1; w < NUM_WORDS; w++) common_w ^= tuple_i[w*WORD_W +: WORD_W];
  end

  assign hi_w   = common_w ^ flow_w ^ (flow_w >> HALF);
  assign lo_w   = {common_w[HALF-1:0], common_w[WORD_W-1:HALF]};
  // flow word joins the low word only after key bit 0 has used it
  assign lo_mix = lo_w ^ flow_w ^ (flow_w << HALF);

  for (genvar g = 1; g < HALF; g++) begin : g_terms
    assign lo_terms[g] = key_i[g]      ? (lo_mix >> g) : '0;
    assign hi_terms[g] = key_i[HALF+g] ? (hi_w >> g)   : '0;
  end

  always_comb begin
    hash_o = (key_i[0] ? lo_w : '0) ^ (key_i[HALF] ? hi_w : '0);
    for (int i = 1; i < HALF; i++) hash_o ^= lo_terms[i] ^ hi_terms[i];
  end
endmodule

// File: rtl/bucket_select.sv
module bucket_select
  import flow_hash_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned BKT_W     = 16,
  parameter int unsigned PERF_BASE = 11,
  parameter int unsigned SIG_BASE  = 13
) (
  input  logic [WORD_W-1:0] hash_i,
  input  logic              mode_i,
  input  logic [1:0]        alloc_i,
  output logic [BKT_W-1:0]  bucket_o
);
  int unsigned keep_bits;

  always_comb begin
    keep_bits = ((hash_mode_e'(mode_i) == MODE_SIGNATURE) ? SIG_BASE : PERF_BASE)
                + alloc_step(alloc_i);
    for (int b = 0; b < BKT_W; b++) bucket_o[b] = hash_i[b] & (b < keep_bits);
  end
endmodule

// File: rtl/flow_hash_engine.sv
module flow_hash_engine
  import flow_hash_pkg::*;
#(
  parameter int unsigned WORD_W    = 32,
  parameter int unsigned NUM_WORDS = 14,
  parameter int unsigned PERF_BASE = 11,
  parameter int unsigned SIG_BASE  = 13
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic                        in_valid_i,
  output logic                        in_ready_o,
  input  logic [NUM_WORDS*WORD_W-1:0] tuple_i,
  input  logic [WORD_W-1:0]           bkt_key_i,
  input  logic [WORD_W-1:0]           sig_key_i,
  input  logic                        mode_i,
  input  logic [1:0]                  alloc_i,
  output logic                        out_valid_o,
  input  logic                        out_ready_i,
  output logic [WORD_W-1:0]           raw_hash_o,
  output logic [WORD_W/2-1:0]         bucket_o,
  output logic [WORD_W-1:0]           sig_word_o
);
  localparam int unsigned HALF    = WORD_W / 2;
  localparam int unsigned PERF_MAX = PERF_BASE + 2;
  localparam int unsigned SIG_MAX  = SIG_BASE + 2;

  logic [WORD_W-1:0] bkt_hash, sig_hash, raw_q, sig_q;
  logic [HALF-1:0]   bkt_idx, bkt_q;
  logic              valid_q, mode_q, accept;

  keyed_hash #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) i_bkt_hash (
    .tuple_i(tuple_i), .key_i(bkt_key_i), .hash_o(bkt_hash)
  );

  keyed_hash #(.WORD_W(WORD_W), .NUM_WORDS(NUM_WORDS)) i_sig_hash (
    .tuple_i(tuple_i), .key_i(sig_key_i), .hash_o(sig_hash)
  );

  bucket_select #(
    .WORD_W(WORD_W), .BKT_W(HALF), .PERF_BASE(PERF_BASE), .SIG_BASE(SIG_BASE)
  ) i_bucket_select (
    .hash_i(bkt_hash), .mode_i(mode_i), .alloc_i(alloc_i), .bucket_o(bkt_idx)
  );

  assign in_ready_o = !valid_q || out_ready_i;
  assign accept     = in_valid_i && in_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      raw_q   <= '0;
      sig_q   <= '0;
      bkt_q   <= '0;
      mode_q  <= 1'b0;
    end else begin
      if (accept) begin
        valid_q <= 1'b1;
        raw_q   <= bkt_hash;
        sig_q   <= sig_hash;
        bkt_q   <= bkt_idx;
        mode_q  <= mode_i;
      end else if (out_ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign out_valid_o = valid_q;
  assign raw_hash_o  = raw_q;
  assign bucket_o    = bkt_q;
  assign sig_word_o  = {sig_q[HALF-1:0], bkt_q};

  AST_ACCEPT_TO_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_valid_i && in_ready_o |=> out_valid_o); // R1
  AST_HOLD_STALLED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(raw_hash_o)
      && $stable(sig_word_o) && $stable(bucket_o)); // R2
  AST_DRAIN_DROPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && out_ready_i && !in_valid_i |=> !out_valid_o); // R10
  AST_PERF_BKT_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && (mode_q == MODE_PERFECT) |-> (bucket_o >> PERF_MAX) == '0); // R6
  AST_SIG_BKT_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o |-> (bucket_o >> SIG_MAX) == '0); // R7
endmodule

// File: tb/test_flow_hash_engine.sv
`timescale 1ns/1ps
module test_flow_hash_engine;
  localparam int HALF_P = 10;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [447:0] tuple = '0;
  logic [31:0]  bkt_key = '0;
  logic [31:0]  sig_key = '0;
  logic         mode = 1'b0;
  logic [1:0]   alloc = 2'd0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [31:0]  raw_hash;
  logic [15:0]  bucket;
  logic [31:0]  sig_word;

  int checks = 0;
  int bad = 0;
  int cyc = 0;
  bit done = 1'b0;
  int rdy_mode = 0;

  logic [31:0] q_raw[$];
  logic [15:0] q_bkt[$];
  logic [31:0] q_sig[$];
  int          q_acc[$];
  string       q_req[$];
  bit          seen = 1'b0;

  flow_hash_engine i_flow_hash_engine (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready),
    .tuple_i(tuple), .bkt_key_i(bkt_key), .sig_key_i(sig_key), .mode_i(mode),
    .alloc_i(alloc), .out_valid_o(out_valid), .out_ready_i(out_ready),
    .raw_hash_o(raw_hash), .bucket_o(bucket), .sig_word_o(sig_word)
  );

  always #HALF_P clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;
  always @(negedge clk) out_ready <= (rdy_mode == 0) ? 1'b1 : 1'($urandom_range(0, 1));

  function automatic logic [31:0] model(input logic [447:0] t, input logic [31:0] k);
    logic [31:0] c, f, hi, lo, r;
    c = '0;
    for (int w = 1; w < 14; w++) c ^= t[w*32 +: 32];
    f  = t[31:0];
    hi = c ^ f ^ (f >> 16);
    lo = {c[15:0], c[31:16]};
    r  = '0;
    if (k[0])  r ^= lo;
    if (k[16]) r ^= hi;
    lo ^= f ^ (f << 16);
    for (int i = 15; i >= 1; i--) begin
      if (k[i])    r ^= lo >> i;
      if (k[16+i]) r ^= hi >> i;
    end
    return r;
  endfunction

  function automatic logic [15:0] model_bkt(input logic [31:0] h, input logic m,
                                            input logic [1:0] a);
    int n;
    n = (m ? 13 : 11) + ((a == 2'd3) ? 2 : int'(a));
    return h[15:0] & 16'((32'd1 << n) - 1);
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // entered at a falling edge; leaves in_valid high at the next falling edge
  task automatic send(input logic [447:0] t, input logic [31:0] bk, input logic [31:0] sk,
                      input logic m, input logic [1:0] a, input bit ov,
                      input logic [31:0] ov_raw, input string req);
    logic [31:0] er;
    logic [15:0] eb;
    er = model(t, bk);
    if (ov) begin
      check(er == ov_raw, req, "model", er, ov_raw);
      er = ov_raw;
    end
    eb = model_bkt(er, m, a);
    in_valid = 1'b1; tuple = t; bkt_key = bk; sig_key = sk; mode = m; alloc = a;
    forever begin
      #5;
      if (in_ready) begin
        q_raw.push_back(er);
        q_bkt.push_back(eb);
        q_sig.push_back({model(t, sk)[15:0], eb});
        q_acc.push_back(cyc);
        q_req.push_back(req);
        @(negedge clk);
        break;
      end
      @(negedge clk);
    end
  endtask

  task automatic idle();
    in_valid = 1'b0;
    @(negedge clk);
  endtask

  function automatic logic [447:0] rnd_tuple();
    logic [447:0] t;
    for (int w = 0; w < 14; w++) t[w*32 +: 32] = $urandom;
    return t;
  endfunction

  // monitor: compare the head item every valid cycle (R2 hold, R3 value)
  initial begin
    forever begin
      @(negedge clk);
      #2;
      if (rst_n && out_valid) begin
        if (q_raw.size() == 0) begin
          check(1'b0, "R1", "unexpected result", raw_hash, 32'h0);
        end else begin
          if (!seen) begin
            check(cyc == q_acc[0] + 1, "R2", "latency", cyc, q_acc[0] + 1);
            seen = 1'b1;
          end
          check(raw_hash == q_raw[0], q_req[0], "raw_hash", raw_hash, q_raw[0]);
          check(bucket == q_bkt[0], q_req[0], "bucket", {16'h0, bucket}, {16'h0, q_bkt[0]});
          check(sig_word == q_sig[0], q_req[0], "sig_word", sig_word, q_sig[0]);
          if (out_ready) begin
            void'(q_raw.pop_front()); void'(q_bkt.pop_front()); void'(q_sig.pop_front());
            void'(q_acc.pop_front()); void'(q_req.pop_front());
            seen = 1'b0;
          end
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    logic [447:0] t;
    int start_cyc;
    #(HALF_P * 3);
    // R9 reset state
    check(out_valid == 1'b0, "R9", "out_valid in reset", {31'h0, out_valid}, 32'h0);
    check(in_ready == 1'b1, "R9", "in_ready in reset", {31'h0, in_ready}, 32'h1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(out_valid == 1'b0, "R9", "out_valid after reset", {31'h0, out_valid}, 32'h0);

    // R5 zero key
    send(rnd_tuple(), 32'h0, 32'h0, 1'b1, 2'd2, 1'b1, 32'h0, "R5");
    idle();
    // R4 delayed flow word
    t = '0; t[31:0] = 32'h12345678;
    send(t, 32'h0001_0000, 32'h0000_0001, 1'b0, 2'd0, 1'b1, 32'h1234_444C, "R4");
    send(t, 32'h0000_0001, 32'h0001_0000, 1'b0, 2'd1, 1'b1, 32'h0000_0000, "R4");
    send(t, 32'h0000_0002, 32'h0000_0002, 1'b1, 2'd0, 1'b1, 32'h2226_2B3C, "R4");
    idle();

    // R3 R6 R7 R8 every mode and allocation code
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < 4; a++) begin
        t = rnd_tuple();
        t[64 +: 32] = 32'hFFFF_FFFF;
        send(t, 32'hFFFF_FFFF, $urandom, 1'(m), 2'(a), 1'b0, 32'h0, m ? "R7" : "R6");
        send(rnd_tuple(), $urandom, $urandom, 1'(m), 2'(a), 1'b0, 32'h0, "R8");
      end
    idle();

    // R10 back-to-back with consumer always ready
    start_cyc = cyc;
    for (int n = 0; n < 20; n++)
      send(rnd_tuple(), $urandom, $urandom, 1'($urandom), 2'($urandom), 1'b0, 32'h0, "R10");
    check(cyc - start_cyc == 20, "R10", "cycles for 20 inputs", cyc - start_cyc, 20);
    idle();
    #2;
    check(out_valid == 1'b0, "R10", "valid after drain", {31'h0, out_valid}, 32'h0);

    // R1 R2 random backpressure
    rdy_mode = 1;
    for (int n = 0; n < 60; n++) begin
      send(rnd_tuple(), $urandom, $urandom, 1'($urandom), 2'($urandom), 1'b0, 32'h0, "R1");
      if (($urandom % 4) == 0) idle();
    end
    idle();
    rdy_mode = 0;
    repeat (5) @(negedge clk);
    check(q_raw.size() == 0, "R2", "items left", q_raw.size(), 0);

    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end
endmodule